// File: doc/BRIEF.md
# Bus Slave Address Decode and Parity Front End

This block sits between a parallel system bus and the local logic of an adapter. It samples the bus pins on a local clock and captures address and cycle status once per bus cycle. The capture happens on the first clock that sees the address-latch strobe fall. When a cycle carries no address-latch strobe, it happens on the first clock that sees the command strobe fall. The captured 3-bit space/status code is decoded into memory read, memory write, I/O read, I/O write, or no cycle. The captured address is compared against a memory window, or, for I/O cycles, against a 16-bit I/O window. On a match, the block drives active-low selected feedback, the two active-low port-size lines and a ready line that can stretch the cycle by a set number of clocks.

A matching command produces a single-clock local read strobe at its leading edge, or a single-clock local write strobe at its trailing edge. For reads, the block drives the local read data onto the bus with odd parity on every byte lane. It keeps driving for one clock after the command ends. Address parity is checked per byte when its enable is low. Write data parity is checked per byte when its enable is low. Either error pulls a sticky channel-check line low until reset. When the 24-bit address enable is high, the top address byte is neither compared nor parity-checked.

Top module: `bus_slave_front`

## Requirements
- R1: The code {mio, s0_n, s1_n} is decoded as follows: 3'b001 is an I/O write, 3'b010 is an I/O read, 3'b101 is a memory write and 3'b110 is a memory read. Codes with s0_n = s1_n (00 reserved, 11 inactive) never select the block and never produce a local strobe.
- R2: Address and status are captured on the first clock that samples adl_n low after it was high. If no such capture happened in the cycle, they are captured on the first clock that samples cmd_n low after it was high. Address changes after the capture do not alter loc_addr.
- R3: A memory cycle hits when (A & MEM_MASK) == MEM_BASE. When m24 is high, bits 31:24 are taken as zero. An I/O cycle hits when (A[15:0] & IO_MASK) == IO_BASE, and bits 31:16 are ignored. loc_addr carries the effective address: upper 16 bits zero for I/O, upper 8 bits zero for memory with m24.
- R4: A read hit gives a one-clock loc_rd pulse on the clock that detects the command leading edge. A write hit gives a one-clock loc_wr pulse on the clock that first samples cmd_n high. In that pulse, loc_wdata holds data_in as sampled on the last clock cmd_n was low. The two strobes are never high together.
- R5: On a read hit, data_oe rises on the clock that detects the command leading edge. While cmd_n is low, data_out follows loc_rdata each clock, and dpar_out bit i is the odd parity of byte lane i. data_oe stays high for one clock after cmd_n is sampled high, then falls.
- R6: On a hit, sel_fb_n goes low on the capture clock. It returns high on the clock that samples cmd_n high. On a miss, it stays high.
- R7: While setup_n is sampled low, the next clock shows sel_fb_n, ds16_n, ds32_n and rdy all high, and no local strobe occurs.
- R8: While selected, a PORT_SIZE of 32 drives ds16_n and ds32_n both low, 16 drives only ds16_n low, and 8 drives neither. Both lines are high while unselected. ds32_n is never low while ds16_n is high.
- R9: With WAIT_STATES > 0, rdy goes low on the capture clock of a hit. It goes high again WAIT_STATES clocks after the clock that detects the command leading edge. rdy is low only while sel_fb_n is low.
- R10: With aparen_n low at capture on a hit, each address byte i must have odd parity together with apar[i]. When m24 is high, byte 3 is not checked. A failure drives chck_n low, and it stays low until rst.
- R11: With dparen_n low on the last clock cmd_n was low during a write hit, each data lane must have odd parity together with dpar_in. A failure drives chck_n low until rst. With the enable high, bad parity has no effect.
- R12: After reset, sel_fb_n, ds16_n, ds32_n, rdy and chck_n are high, and data_oe, loc_rd and loc_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| adl_n | input | 1 | Address-latch strobe, active low |
| cmd_n | input | 1 | Command strobe, active low |
| mio | input | 1 | 1 for memory space, 0 for I/O space |
| s0_n | input | 1 | Status bit 0, active low |
| s1_n | input | 1 | Status bit 1, active low |
| addr | input | ADDR_W | Unlatched bus address |
| m24 | input | 1 | 24-bit address enable, high means bits 31:24 undefined |
| aparen_n | input | 1 | Address parity valid, active low |
| apar | input | ADDR_W/8 | Odd parity per address byte |
| data_in | input | DATA_W | Bus data as received |
| dparen_n | input | 1 | Write data parity valid, active low |
| dpar_in | input | DATA_W/8 | Odd parity per received data lane |
| setup_n | input | 1 | Slot setup select, active low |
| loc_rdata | input | DATA_W | Read data from local logic for loc_addr |
| sel_fb_n | output | 1 | Selected feedback, active low |
| ds16_n | output | 1 | Port at least 16 bits wide, active low |
| ds32_n | output | 1 | Port 32 bits wide, active low |
| rdy | output | 1 | Ready; low stretches the cycle |
| chck_n | output | 1 | Sticky parity error, active low |
| data_out | output | DATA_W | Read data for the bus |
| dpar_out | output | DATA_W/8 | Odd parity per driven lane |
| data_oe | output | 1 | Drive enable for data_out and dpar_out |
| loc_addr | output | ADDR_W | Captured effective address |
| loc_rd | output | 1 | One-clock local read strobe |
| loc_wr | output | 1 | One-clock local write strobe |
| loc_wdata | output | DATA_W | Write data for loc_wr |

## Verification
The bench changes the address right after capture. A design that latched on every clock would then write to a wrong address. It runs a cycle without an address-latch strobe, so a design that needs that strobe would never select. With the 24-bit enable, it drives garbage in the top address byte and a wrong parity bit there. A design that still compared or checked that byte would miss the cycle or raise channel check. It also covers reserved and inactive status codes, setup select, and parity errors with the enables both off and on. Here a wrong design would select when it should not, or miss an error, or let channel check clear before reset.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_IO_WR  = 3'd1,
    CYC_IO_RD  = 3'd2,
    CYC_MEM_WR = 3'd3,
    CYC_MEM_RD = 3'd4
  } cyc_t;

  function automatic cyc_t decode_cycle(input logic mio, input logic s0_n, input logic s1_n);
    cyc_t c;
    case ({mio, s0_n, s1_n})
      3'b001:  c = CYC_IO_WR;
      3'b010:  c = CYC_IO_RD;
      3'b101:  c = CYC_MEM_WR;
      3'b110:  c = CYC_MEM_RD;
      default: c = CYC_NONE;
    endcase
    return c;
  endfunction

  function automatic logic is_read(input cyc_t c);
    return (c == CYC_IO_RD) || (c == CYC_MEM_RD);
  endfunction

  function automatic logic is_write(input cyc_t c);
    return (c == CYC_IO_WR) || (c == CYC_MEM_WR);
  endfunction

endpackage

// File: rtl/bsf_edges.sv
module bsf_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_n;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) prev_n[i] <= 1'b1;
      else     prev_n[i] <= lvl_n[i];
    end
    assign fall[i] = prev_n[i] & ~lvl_n[i];
    assign rise[i] = ~prev_n[i] & lvl_n[i];
  end
endmodule

// File: rtl/bsf_parity.sv
module bsf_parity #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] bytes_in,
  input  logic [LANES-1:0]   par_in,
  output logic [LANES-1:0]   lane_ok,
  output logic [LANES-1:0]   par_gen
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ok[i] = ^{bytes_in[8*i +: 8], par_in[i]};
    assign par_gen[i] = ~^bytes_in[8*i +: 8];
  end
endmodule

// File: rtl/bsf_addr_decode.sv
module bsf_addr_decode
  import bsf_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          IO_W     = 16,
  parameter logic [31:0] MEM_BASE = 32'h00C4_0000,
  parameter logic [31:0] MEM_MASK = 32'hFFFF_0000,
  parameter logic [15:0] IO_BASE  = 16'h03A0,
  parameter logic [15:0] IO_MASK  = 16'hFFF0
) (
  input  logic              mio,
  input  logic              s0_n,
  input  logic              s1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              m24,
  output cyc_t              cyc,
  output logic              hit,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int NARROW_W = 24;

  logic [ADDR_W-1:0] mem_eff;
  logic [ADDR_W-1:0] io_eff;
  logic              is_io;
  logic              is_mem;

  always_comb begin
    cyc    = decode_cycle(mio, s0_n, s1_n);
    is_io  = (cyc == CYC_IO_RD) || (cyc == CYC_IO_WR);
    is_mem = (cyc == CYC_MEM_RD) || (cyc == CYC_MEM_WR);

    mem_eff = addr;
    if (m24) mem_eff[ADDR_W-1:NARROW_W] = '0;

    io_eff = '0;
    io_eff[IO_W-1:0] = addr[IO_W-1:0];

    eff_addr = is_io ? io_eff : mem_eff;
    hit = (is_io  && ((io_eff[IO_W-1:0] & IO_MASK) == IO_BASE)) ||
          (is_mem && ((mem_eff & ADDR_W'(MEM_MASK)) == ADDR_W'(MEM_BASE)));
  end
endmodule

// File: rtl/bus_slave_front.sv
module bus_slave_front
  import bsf_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          PORT_SIZE   = 32,
  parameter int          WAIT_STATES = 2,
  parameter logic [31:0] MEM_BASE    = 32'h00C4_0000,
  parameter logic [31:0] MEM_MASK    = 32'hFFFF_0000,
  parameter logic [15:0] IO_BASE     = 16'h03A0,
  parameter logic [15:0] IO_MASK     = 16'hFFF0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adl_n,
  input  logic                cmd_n,
  input  logic                mio,
  input  logic                s0_n,
  input  logic                s1_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                m24,
  input  logic                aparen_n,
  input  logic [ADDR_W/8-1:0] apar,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                dparen_n,
  input  logic [DATA_W/8-1:0] dpar_in,
  input  logic                setup_n,
  input  logic [DATA_W-1:0]   loc_rdata,
  output logic                sel_fb_n,
  output logic                ds16_n,
  output logic                ds32_n,
  output logic                rdy,
  output logic                chck_n,
  output logic [DATA_W-1:0]   data_out,
  output logic [DATA_W/8-1:0] dpar_out,
  output logic                data_oe,
  output logic [ADDR_W-1:0]   loc_addr,
  output logic                loc_rd,
  output logic                loc_wr,
  output logic [DATA_W-1:0]   loc_wdata
);
  localparam int ALANES     = ADDR_W / 8;
  localparam int DLANES     = DATA_W / 8;
  localparam int NARROW_LN  = 3;
  localparam int CNT_W      = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic WIDE16   = (PORT_SIZE >= 16);
  localparam logic WIDE32   = (PORT_SIZE >= 32);
  localparam logic HAS_WAIT = (WAIT_STATES > 0);

  // strobe edges: index 0 = address latch, index 1 = command
  logic [1:0] fall, rise;
  bsf_edges #(.N(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .lvl_n({cmd_n, adl_n}),
    .fall (fall),
    .rise (rise)
  );

  cyc_t              dec_cyc;
  logic              dec_hit;
  logic [ADDR_W-1:0] dec_addr;
  bsf_addr_decode #(
    .ADDR_W  (ADDR_W),
    .IO_W    (16),
    .MEM_BASE(MEM_BASE),
    .MEM_MASK(MEM_MASK),
    .IO_BASE (IO_BASE),
    .IO_MASK (IO_MASK)
  ) u_dec (
    .mio     (mio),
    .s0_n    (s0_n),
    .s1_n    (s1_n),
    .addr    (addr),
    .m24     (m24),
    .cyc     (dec_cyc),
    .hit     (dec_hit),
    .eff_addr(dec_addr)
  );

  logic [ALANES-1:0] a_ok, a_gen_unused;
  bsf_parity #(.LANES(ALANES)) u_apar (
    .bytes_in(addr),
    .par_in  (apar),
    .lane_ok (a_ok),
    .par_gen (a_gen_unused)
  );

  logic [DATA_W-1:0] wdat_q;
  logic [DLANES-1:0] wpar_q;
  logic              wpen_q;
  logic [DLANES-1:0] w_ok, w_gen_unused;
  bsf_parity #(.LANES(DLANES)) u_wpar (
    .bytes_in(wdat_q),
    .par_in  (wpar_q),
    .lane_ok (w_ok),
    .par_gen (w_gen_unused)
  );

  logic [DLANES-1:0] r_ok_unused, r_gen;
  bsf_parity #(.LANES(DLANES)) u_rpar (
    .bytes_in(loc_rdata),
    .par_in  ('0),
    .lane_ok (r_ok_unused),
    .par_gen (r_gen)
  );

  // lanes that take part in the address parity check
  logic [ALANES-1:0] a_mask;
  always_comb begin
    for (int i = 0; i < ALANES; i++) a_mask[i] = !(m24 && (i >= NARROW_LN));
  end

  logic adl_fall, cmd_fall, cmd_rise;
  logic latch_ev, hit_live, hit_now, a_bad;
  assign adl_fall = fall[0];
  assign cmd_fall = fall[1];
  assign cmd_rise = rise[1];

  logic             have_lat, hit_q, oe_tail;
  cyc_t             cyc_q;
  logic [CNT_W-1:0] wait_cnt;

  always_comb begin
    latch_ev = adl_fall | (cmd_fall & ~have_lat);
    hit_live = dec_hit & setup_n;
    hit_now  = latch_ev ? hit_live : hit_q;
    a_bad    = hit_live & ~aparen_n & |(~a_ok & a_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_lat  <= 1'b0;
      hit_q     <= 1'b0;
      cyc_q     <= CYC_NONE;
      oe_tail   <= 1'b0;
      wait_cnt  <= '0;
      sel_fb_n  <= 1'b1;
      ds16_n    <= 1'b1;
      ds32_n    <= 1'b1;
      rdy       <= 1'b1;
      chck_n    <= 1'b1;
      data_oe   <= 1'b0;
      data_out  <= '0;
      dpar_out  <= '0;
      loc_addr  <= '0;
      loc_rd    <= 1'b0;
      loc_wr    <= 1'b0;
      loc_wdata <= '0;
      wdat_q    <= '0;
      wpar_q    <= '0;
      wpen_q    <= 1'b0;
    end else begin
      loc_rd <= 1'b0;
      loc_wr <= 1'b0;

      if (!cmd_n) begin
        wdat_q   <= data_in;
        wpar_q   <= dpar_in;
        wpen_q   <= ~dparen_n;
        data_out <= loc_rdata;
        dpar_out <= r_gen;
      end

      if (latch_ev) begin
        have_lat <= 1'b1;
        hit_q    <= hit_live;
        cyc_q    <= dec_cyc;
        loc_addr <= dec_addr;
        sel_fb_n <= ~hit_live;
        ds16_n   <= ~(hit_live & WIDE16);
        ds32_n   <= ~(hit_live & WIDE32);
        rdy      <= ~(hit_live & HAS_WAIT);
        if (a_bad) chck_n <= 1'b0;
      end

      if (cmd_fall) begin
        wait_cnt <= CNT_W'(WAIT_STATES);
        if (hit_now && is_read(latch_ev ? dec_cyc : cyc_q)) begin
          loc_rd  <= 1'b1;
          data_oe <= 1'b1;
        end
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
        if (wait_cnt == CNT_W'(1)) rdy <= 1'b1;
      end

      if (oe_tail) begin
        data_oe <= 1'b0;
        oe_tail <= 1'b0;
      end

      if (cmd_rise) begin
        have_lat <= 1'b0;
        hit_q    <= 1'b0;
        sel_fb_n <= 1'b1;
        ds16_n   <= 1'b1;
        ds32_n   <= 1'b1;
        rdy      <= 1'b1;
        wait_cnt <= '0;
        if (data_oe) oe_tail <= 1'b1;
        if (hit_q && is_write(cyc_q)) begin
          loc_wr    <= 1'b1;
          loc_wdata <= wdat_q;
          if (wpen_q && !(&w_ok)) chck_n <= 1'b0;
        end
      end

      if (!setup_n) begin
        hit_q    <= 1'b0;
        sel_fb_n <= 1'b1;
        ds16_n   <= 1'b1;
        ds32_n   <= 1'b1;
        rdy      <= 1'b1;
        wait_cnt <= '0;
        loc_rd   <= 1'b0;
        loc_wr   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker (
  input logic clk,
  input logic rst,
  input logic setup_n,
  input logic sel_fb_n,
  input logic ds16_n,
  input logic ds32_n,
  input logic rdy,
  input logic chck_n,
  input logic loc_rd,
  input logic loc_wr
);
  a_r7_setup_quiet: assert property (@(posedge clk) disable iff (rst)
    !setup_n |=> (sel_fb_n && rdy));

  a_r8_no_wide_alone: assert property (@(posedge clk) disable iff (rst)
    !(ds16_n && !ds32_n));

  a_r8_size_follows_sel: assert property (@(posedge clk) disable iff (rst)
    sel_fb_n |-> (ds16_n && ds32_n));

  a_r9_wait_needs_sel: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> !sel_fb_n);

  a_r10_chck_sticky: assert property (@(posedge clk) disable iff (rst)
    !chck_n |=> !chck_n);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(loc_rd && loc_wr));

  a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
    loc_rd |=> !loc_rd);
endmodule

bind bus_slave_front bsf_checker u_bsf_checker (
  .clk     (clk),
  .rst     (rst),
  .setup_n (setup_n),
  .sel_fb_n(sel_fb_n),
  .ds16_n  (ds16_n),
  .ds32_n  (ds32_n),
  .rdy     (rdy),
  .chck_n  (chck_n),
  .loc_rd  (loc_rd),
  .loc_wr  (loc_wr)
);

// File: tb/bus_slave_front_bench.sv
module bus_slave_front_bench;
  localparam logic [31:0] RKEY = 32'h5A5A_1234;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adl_n = 1'b1, cmd_n = 1'b1, mio = 1'b0, s0_n = 1'b1, s1_n = 1'b1;
  logic [31:0] addr = '0;
  logic        m24 = 1'b0, aparen_n = 1'b1, dparen_n = 1'b1, setup_n = 1'b1;
  logic [3:0]  apar = '0, dpar_in = '0;
  logic [31:0] data_in = '0;
  logic [31:0] loc_rdata;
  logic        sel_fb_n, ds16_n, ds32_n, rdy, chck_n, data_oe, loc_rd, loc_wr;
  logic [31:0] data_out, loc_addr, loc_wdata;
  logic [3:0]  dpar_out;

  always #2 clk = ~clk;

  assign loc_rdata = loc_addr ^ RKEY;

  bus_slave_front u_bus_slave_front (
    .clk(clk), .rst(rst), .adl_n(adl_n), .cmd_n(cmd_n), .mio(mio),
    .s0_n(s0_n), .s1_n(s1_n), .addr(addr), .m24(m24), .aparen_n(aparen_n),
    .apar(apar), .data_in(data_in), .dparen_n(dparen_n), .dpar_in(dpar_in),
    .setup_n(setup_n), .loc_rdata(loc_rdata), .sel_fb_n(sel_fb_n),
    .ds16_n(ds16_n), .ds32_n(ds32_n), .rdy(rdy), .chck_n(chck_n),
    .data_out(data_out), .dpar_out(dpar_out), .data_oe(data_oe),
    .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_wdata(loc_wdata)
  );

  typedef struct { logic wr; logic [31:0] a; logic [31:0] d; } item_t;
  item_t sbq[$];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic logic [3:0] oddp(input logic [31:0] v);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^v[8*i +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare local strobes against the scoreboard
  always @(negedge clk) begin
    if (!rst && (loc_wr || loc_rd)) begin
      if (sbq.size() == 0) begin
        chk("R1 unexpected local strobe", {30'd0, loc_wr, loc_rd}, 32'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk("R4 strobe kind", {31'd0, loc_wr}, {31'd0, it.wr});
        chk("R2 R3 strobe address", loc_addr, it.a);
        if (it.wr) chk("R4 write data", loc_wdata, it.d);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cyc(input logic m, input logic [1:0] st, input logic [31:0] a,
                     input logic w24, input logic apen_n, input logic [3:0] aflip,
                     input logic [31:0] wd, input logic dpen_n, input logic [3:0] dflip,
                     input logic use_adl, input logic hit, input string tag);
    logic        is_wr, is_rd;
    logic [31:0] ea;
    is_wr = (st == 2'b01);
    is_rd = (st == 2'b10);
    ea = !m ? {16'h0, a[15:0]} : (w24 ? {8'h0, a[23:0]} : a);
    if (hit && (is_wr || is_rd)) sbq.push_back('{is_wr, ea, wd});
    mio = m; s0_n = st[1]; s1_n = st[0]; addr = a; m24 = w24;
    aparen_n = apen_n; apar = oddp(a) ^ aflip;
    @(negedge clk);
    if (use_adl) adl_n = 1'b0;
    @(negedge clk);
    if (use_adl) begin
      chk({tag, " R6 sel on latch"}, {31'd0, sel_fb_n}, {31'd0, ~hit});
      chk({tag, " R8 size"}, {30'd0, ds16_n, ds32_n}, hit ? 32'd0 : 32'd3);
      chk({tag, " R9 ready low on latch"}, {31'd0, rdy}, {31'd0, ~hit});
    end
    adl_n = 1'b1; cmd_n = 1'b0; data_in = wd; dparen_n = dpen_n;
    dpar_in = oddp(wd) ^ dflip;
    @(negedge clk);
    if (!use_adl) chk({tag, " R2 latch on command"}, {31'd0, sel_fb_n}, {31'd0, ~hit});
    chk({tag, " R9 ready e2"}, {31'd0, rdy}, {31'd0, ~hit});
    chk({tag, " R5 oe on read"}, {31'd0, data_oe}, {31'd0, hit && is_rd});
    addr = ~a;
    @(negedge clk);
    chk({tag, " R9 ready e3"}, {31'd0, rdy}, {31'd0, ~hit});
    @(negedge clk);
    chk({tag, " R9 ready release"}, {31'd0, rdy}, 32'd1);
    @(negedge clk);
    if (hit && is_rd) begin
      chk({tag, " R5 read data"}, data_out, ea ^ RKEY);
      chk({tag, " R5 read parity"}, {28'd0, dpar_out}, {28'd0, oddp(ea ^ RKEY)});
    end
    cmd_n = 1'b1;
    @(negedge clk);
    chk({tag, " R6 sel release"}, {31'd0, sel_fb_n}, 32'd1);
    chk({tag, " R5 oe hold"}, {31'd0, data_oe}, {31'd0, hit && is_rd});
    @(negedge clk);
    chk({tag, " R5 oe off"}, {31'd0, data_oe}, 32'd0);
    aparen_n = 1'b1; dparen_n = 1'b1; m24 = 1'b0; s0_n = 1'b1; s1_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R12 reset strobes high", {27'd0, sel_fb_n, ds16_n, ds32_n, rdy, chck_n}, 32'h1F);
    chk("R12 reset strobes low", {29'd0, data_oe, loc_rd, loc_wr}, 32'd0);

    cyc(1'b1, 2'b01, 32'h00C4_0010, 0, 1, 4'h0, 32'hDEAD_BEEF, 1, 4'h0, 1, 1, "R1 mem wr");
    cyc(1'b1, 2'b10, 32'h00C4_ABC0, 0, 1, 4'h0, 32'h0, 1, 4'h0, 1, 1, "R1 mem rd");
    cyc(1'b0, 2'b01, 32'h5A5A_03A4, 0, 1, 4'h0, 32'h1357_9BDF, 1, 4'h0, 0, 1, "R3 io wr");
    cyc(1'b0, 2'b10, 32'h0000_03AF, 0, 1, 4'h0, 32'h0, 1, 4'h0, 1, 1, "R3 io rd");
    cyc(1'b1, 2'b01, 32'h00C5_0000, 0, 1, 4'h0, 32'h1, 1, 4'h0, 1, 0, "R3 mem miss");
    cyc(1'b0, 2'b10, 32'h0000_03B0, 0, 1, 4'h0, 32'h0, 1, 4'h0, 1, 0, "R3 io miss");
    cyc(1'b1, 2'b01, 32'h77C4_1230, 1, 0, 4'h8, 32'hCAFE_0001, 1, 4'h0, 1, 1, "R3 m24 hit");
    chk("R10 top byte parity ignored with m24", {31'd0, chck_n}, 32'd1);
    cyc(1'b1, 2'b01, 32'h77C4_1230, 0, 1, 4'h0, 32'h2, 1, 4'h0, 1, 0, "R3 no m24 miss");
    cyc(1'b1, 2'b00, 32'h00C4_0020, 0, 1, 4'h0, 32'h3, 1, 4'h0, 1, 0, "R1 reserved");
    cyc(1'b0, 2'b11, 32'h0000_03A0, 0, 1, 4'h0, 32'h4, 1, 4'h0, 1, 0, "R1 inactive");
    setup_n = 1'b0;
    cyc(1'b1, 2'b01, 32'h00C4_0030, 0, 1, 4'h0, 32'h5, 1, 4'h0, 1, 0, "R7 setup");
    setup_n = 1'b1;
    cyc(1'b1, 2'b10, 32'h00C4_0040, 0, 1, 4'h2, 32'h0, 1, 4'h0, 1, 1, "R10 apar off");
    cyc(1'b1, 2'b01, 32'h00C4_0050, 0, 1, 4'h0, 32'h6, 1, 4'h4, 1, 1, "R11 dpar off");
    chk("R11 parity ignored when disabled", {31'd0, chck_n}, 32'd1);
    cyc(1'b1, 2'b01, 32'h00C4_0060, 0, 1, 4'h0, 32'h7788_99AA, 0, 4'h4, 1, 1, "R11 dpar err");
    chk("R11 write parity error", {31'd0, chck_n}, 32'd0);
    cyc(1'b0, 2'b01, 32'h0000_03A1, 0, 1, 4'h0, 32'h8, 0, 4'h0, 1, 1, "R10 clean");
    chk("R10 chck sticky", {31'd0, chck_n}, 32'd0);
    do_reset();
    chk("R12 chck cleared by reset", {31'd0, chck_n}, 32'd1);
    cyc(1'b1, 2'b10, 32'h00C4_0070, 0, 0, 4'h2, 32'h0, 1, 4'h0, 1, 1, "R10 apar err");
    chk("R10 address parity error", {31'd0, chck_n}, 32'd0);

    repeat (2) @(negedge clk);
    chk("R1 no pending strobes", sbq.size(), 32'd0);
    finish_run();
  end
endmodule